// File: doc/BRIEF.md
# Latched SRAM cycle controller

This block sits between a simple host request port and an asynchronous static RAM whose address, chip-enable and write-data inputs pass through level-sensitive latches. It accepts one read or write at a time. It then drives the memory pins through a fixed series of phases. First the address latch is opened and closed. For writes, the data latch is then opened and closed and a byte-selective write strobe follows. For reads, the output enable is lowered for a timed access window. The host sees a ready/done handshake, and read data is returned alongside the done pulse.

Every minimum interval the memory needs is a parameter counted in clock cycles. These cover address and chip-enable set-up and hold around the address-latch fall, the address-latch pulse width, data set-up and hold around the data-latch fall, the write strobe width, and the access times. A zero parameter is raised to one cycle. The read wait is worked out from the access times and the cycles already spent on address latching. The memory data bus is presented as separate out, in and drive-enable signals, so a pad ring or board model can form the shared bus.

Top module: `sram_ctl`

## Requirements
- R1: Out of reset, ready_o is 1 and done_o is 0. The chip enable, both write enables and the output enable are high (inactive). Both latch controls are low, and the data bus is not driven.
- R2: ready_o falls in the cycle after a request is accepted and stays low until done_o. done_o is a single-cycle pulse, and ready_o is high in the following cycle.
- R3: The address-latch control stays high for at least max(T_ASETUP, T_ALPULSE) cycles, with the address stable and the chip enable low. After it falls, the address and the low chip enable are held for at least T_AHOLD cycles.
- R4: For a write, the data bus carries the write data while the data-latch control is high for at least T_DSETUP cycles. After that control falls, the data is held at least T_DHOLD cycles before any write enable goes low, and it stays unchanged until the strobe ends.
- R5: Host mask bit 0 selects the lower write enable (sram_we_n_o[0], data bits 0 to 8). Mask bit 1 selects the upper write enable (sram_we_n_o[1], bits 9 to 17). A selected enable is low for at least T_WRPULSE cycles while the chip enable is low. An unselected byte lane keeps its stored value.
- R6: Both write enables are high in the cycle before and the cycle of any change on the memory address.
- R7: The output enable is low only while both write enables are high and the data bus is not driven. Read data is taken from the bus at the end of the read wait and appears on rdata_o together with done_o.
- R8: done_o rises exactly max(T_ASETUP,T_ALPULSE)+T_AHOLD+T_DSETUP+T_DHOLD+T_WRPULSE clock edges after the accepting edge of a write. For a read it rises max(T_ASETUP,T_ALPULSE)+T_AHOLD+W edges after, where W = max(T_OEACC, T_ACCESS minus the address-latch and hold cycles, 1).
- R9: A request held high through done_o is accepted at the clock edge that ends the cycle following done_o.
- R10: rdata_o keeps the value of the last completed read until another read completes, writes included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, taken when ready_o is high |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| be_i | input | LANES | Byte-lane mask, bit 0 = bits 0..8 |
| ready_o | output | 1 | Idle and able to accept |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Last read result |
| sram_addr_o | output | ADDR_W | Memory address |
| sram_al_o | output | 1 | Address latch open (high = transparent) |
| sram_dl_o | output | 1 | Data latch open (high = transparent) |
| sram_ce_n_o | output | 1 | Chip enable, active low |
| sram_we_n_o | output | LANES | Per-lane write enables, active low |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_dq_o | output | DATA_W | Data to memory |
| sram_dq_oe_o | output | 1 | Drive enable for sram_dq_o |
| sram_dq_i | input | DATA_W | Data from memory |

## Verification
Full-word writes and reads at the lowest, highest and an interior address show that the latched address and data reach the same storage word. They also let the bench measure the write and read latency. Mask patterns of both lanes, lower only, upper only and none, written over a known word, separate correct lane steering from swapped or ignored enables. Requests held high across completion show the accept point in back-to-back use. A write placed after a read shows whether the read result is disturbed. A pin monitor measures each latch pulse, hold window, strobe width and bus overlap on every cycle.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AHOLD, ST_DSET, ST_DHOLD, ST_STROBE, ST_READ, ST_DONE
  } ctl_state_e;

  function automatic int cyc_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= (load_val_i == '0) ? '0 : load_val_i - 1'b1;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_lane_dec.sv
module sram_ctl_lane_dec #(
  parameter int LANES = 2
) (
  input  logic             strobe_i,
  input  logic [LANES-1:0] be_i,
  output logic [LANES-1:0] we_n_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign we_n_o[g] = ~(strobe_i & be_i[g]);
  end
endmodule

// File: rtl/sram_ctl_regs.sv
module sram_ctl_regs #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  be_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] rd_dq_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      be_o    <= '0;
    end else if (accept_i) begin
      wr_o    <= wr_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
      be_o    <= be_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (capture_i) rdata_o <= rd_dq_i;
  end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 18,
  parameter int LANE_W    = 9,
  parameter int T_ASETUP  = 1,
  parameter int T_ALPULSE = 1,
  parameter int T_AHOLD   = 1,
  parameter int T_DSETUP  = 1,
  parameter int T_DHOLD   = 1,
  parameter int T_WRPULSE = 2,
  parameter int T_ACCESS  = 2,
  parameter int T_OEACC   = 1,
  localparam int LANES    = DATA_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  be_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_al_o,
  output logic              sram_dl_o,
  output logic              sram_ce_n_o,
  output logic [LANES-1:0]  sram_we_n_o,
  output logic              sram_oe_n_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);
  localparam int C_ADDR  = cyc_max(cyc_max(T_ASETUP, T_ALPULSE), 1);
  localparam int C_AHOLD = cyc_max(T_AHOLD, 1);
  localparam int C_DSET  = cyc_max(T_DSETUP, 1);
  localparam int C_DHOLD = cyc_max(T_DHOLD, 1);
  localparam int C_WR    = cyc_max(T_WRPULSE, 1);
  // address already valid for C_ADDR + C_AHOLD cycles when the read wait starts
  localparam int C_RD    = cyc_max(cyc_max(T_OEACC, T_ACCESS - C_ADDR - C_AHOLD), 1);
  localparam int MAX_C   = cyc_max(cyc_max(cyc_max(C_ADDR, C_AHOLD), cyc_max(C_DSET, C_DHOLD)),
                                   cyc_max(C_WR, C_RD));
  localparam int CNT_W   = $clog2(MAX_C + 1);

  ctl_state_e       state_q, state_d;
  logic             tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_val;
  logic             accept, capture, wr_q;
  logic [LANES-1:0] be_q;

  assign accept  = (state_q == ST_IDLE) && req_i;
  assign capture = (state_q == ST_READ) && tmr_exp;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_i)   state_d = ST_ADDR;
      ST_ADDR:   if (tmr_exp) state_d = ST_AHOLD;
      ST_AHOLD:  if (tmr_exp) state_d = wr_q ? ST_DSET : ST_READ;
      ST_DSET:   if (tmr_exp) state_d = ST_DHOLD;
      ST_DHOLD:  if (tmr_exp) state_d = ST_STROBE;
      ST_STROBE: if (tmr_exp) state_d = ST_DONE;
      ST_READ:   if (tmr_exp) state_d = ST_DONE;
      ST_DONE:                state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_ADDR:   tmr_val = CNT_W'(C_ADDR);
      ST_AHOLD:  tmr_val = CNT_W'(C_AHOLD);
      ST_DSET:   tmr_val = CNT_W'(C_DSET);
      ST_DHOLD:  tmr_val = CNT_W'(C_DHOLD);
      ST_STROBE: tmr_val = CNT_W'(C_WR);
      ST_READ:   tmr_val = CNT_W'(C_RD);
      default:   tmr_val = CNT_W'(1);
    endcase
  end
  assign tmr_load = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_exp)
  );

  sram_ctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .be_i      (be_i),
    .capture_i (capture),
    .rd_dq_i   (sram_dq_i),
    .wr_o      (wr_q),
    .addr_o    (sram_addr_o),
    .wdata_o   (sram_dq_o),
    .be_o      (be_q),
    .rdata_o   (rdata_o)
  );

  sram_ctl_lane_dec #(.LANES(LANES)) u_lane (
    .strobe_i (state_q == ST_STROBE),
    .be_i     (be_q),
    .we_n_o   (sram_we_n_o)
  );

  // pins decoded from the state register only
  assign ready_o      = (state_q == ST_IDLE);
  assign done_o       = (state_q == ST_DONE);
  assign sram_al_o    = (state_q == ST_ADDR);
  assign sram_dl_o    = (state_q == ST_DSET);
  assign sram_oe_n_o  = (state_q != ST_READ);
  assign sram_dq_oe_o = (state_q == ST_DSET) || (state_q == ST_DHOLD) ||
                        (state_q == ST_STROBE);
  assign sram_ce_n_o  = (state_q == ST_IDLE) || (state_q == ST_DONE);
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ready_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_al_o,
  input logic              sram_dl_o,
  input logic              sram_ce_n_o,
  input logic [LANES-1:0]  sram_we_n_o,
  input logic              sram_oe_n_o,
  input logic [DATA_W-1:0] sram_dq_o,
  input logic              sram_dq_oe_o
);
  p_busy_after_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && req_i) |=> !ready_o);
  p_ready_after_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ready_o);
  p_al_fall_setup_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_al_o) |-> (!sram_ce_n_o && $stable(sram_addr_o)));
  p_al_fall_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_al_o) |=> (!sram_ce_n_o && $stable(sram_addr_o)));
  p_dl_fall_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_dl_o) |=> (sram_dq_oe_o && $stable(sram_dq_o)));
  p_strobe_ctx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&sram_we_n_o) |-> (!sram_ce_n_o && sram_dq_oe_o && !sram_dl_o && !sram_al_o));
  p_addr_we_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sram_addr_o) |-> ((&sram_we_n_o) && (&$past(sram_we_n_o))));
  p_oe_safe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_n_o |-> ((&sram_we_n_o) && !sram_dq_oe_o));
endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .ready_o      (ready_o),
  .done_o       (done_o),
  .sram_addr_o  (sram_addr_o),
  .sram_al_o    (sram_al_o),
  .sram_dl_o    (sram_dl_o),
  .sram_ce_n_o  (sram_ce_n_o),
  .sram_we_n_o  (sram_we_n_o),
  .sram_oe_n_o  (sram_oe_n_o),
  .sram_dq_o    (sram_dq_o),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/sram_ctl_tb_top.sv
module sram_ctl_tb_top;
  localparam int AW = 16, DW = 18, LW = 9, NL = 2;
  localparam int TASU = 1, TALP = 1, TAH = 1, TDS = 1, TDH = 1, TWR = 2, TACC = 2, TOE = 1;
  localparam int E_ADDR = (TASU > TALP) ? TASU : TALP;
  localparam int E_RDR  = TACC - E_ADDR - TAH;
  localparam int E_RD   = (TOE > E_RDR) ? TOE : ((E_RDR > 1) ? E_RDR : 1);
  localparam int LAT_WR = E_ADDR + TAH + TDS + TDH + TWR;
  localparam int LAT_RD = E_ADDR + TAH + E_RD;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [NL-1:0] be = '0;
  logic ready, done, al, dl, ce_n, oe_n, dq_oe;
  logic [DW-1:0] rdata, dq_o, dq_i;
  logic [AW-1:0] s_addr;
  logic [NL-1:0] we_n;
  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  sram_ctl #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(LW), .T_ASETUP(TASU), .T_ALPULSE(TALP),
    .T_AHOLD(TAH), .T_DSETUP(TDS), .T_DHOLD(TDH), .T_WRPULSE(TWR), .T_ACCESS(TACC),
    .T_OEACC(TOE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .be_i(be), .ready_o(ready), .done_o(done), .rdata_o(rdata), .sram_addr_o(s_addr),
    .sram_al_o(al), .sram_dl_o(dl), .sram_ce_n_o(ce_n), .sram_we_n_o(we_n),
    .sram_oe_n_o(oe_n), .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i));

  // memory model with level latches
  logic [AW-1:0] a_lat = '0;
  logic          ce_lat_n = 1'b1;
  logic [DW-1:0] d_lat = '0, rd_word;
  logic [DW-1:0] mem [logic [AW-1:0]];

  always_latch if (al) begin a_lat = s_addr; ce_lat_n = ce_n; end
  always_latch if (dl) d_lat = dq_oe ? dq_o : '1;
  always_comb rd_word = mem.exists(a_lat) ? mem[a_lat] : '0;
  assign dq_i = (!ce_lat_n && !oe_n) ? rd_word : 18'h15555;

  always @(posedge clk) begin
    logic [DW-1:0] w;
    if (!ce_lat_n && !(&we_n)) begin
      w = mem.exists(a_lat) ? mem[a_lat] : '0;
      for (int k = 0; k < NL; k++) if (!we_n[k]) w[k*LW +: LW] = d_lat[k*LW +: LW];
      mem[a_lat] = w;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // pin monitor
  int v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r7 = 0;
  int al_run = 0, dl_run = 0, we_run = 0, ah_left = 0, dgap = 0;
  bit d_arm = 0;
  logic p_al = 0, p_dl = 0, p_dq_oe = 0;
  logic [AW-1:0] p_addr = '0, ah_addr = '0;
  logic [NL-1:0] p_we = '1;
  logic [DW-1:0] p_dq = '0;

  always @(negedge clk) if (rst_n) begin
    if (s_addr != p_addr && (!(&we_n) || !(&p_we))) v_r6++;
    if (al) begin
      al_run++;
      if (ce_n || (al_run > 1 && s_addr != p_addr)) v_r3++;
    end
    if (p_al && !al) begin
      if (al_run < E_ADDR) v_r3++;
      al_run = 0; ah_left = TAH; ah_addr = p_addr;
    end
    if (ah_left > 0) begin
      if (s_addr != ah_addr || ce_n) v_r3++;
      ah_left--;
    end
    if (dl) begin
      dl_run++;
      if (!dq_oe || (dl_run > 1 && dq_o != p_dq)) v_r4++;
    end
    if (p_dl && !dl) begin
      if (dl_run < TDS) v_r4++;
      dl_run = 0; d_arm = 1; dgap = 0;
    end
    if (d_arm && (&we_n)) dgap++;
    if (d_arm && !(&we_n)) begin
      if (dgap < TDH) v_r4++;
      d_arm = 0;
    end
    if (dq_oe && p_dq_oe && !dl && dq_o != p_dq) v_r4++;
    if (!(&we_n)) begin
      we_run++;
      if (ce_n) v_r5++;
    end else if (we_run > 0) begin
      if (we_run < TWR) v_r5++;
      we_run = 0;
    end
    if (!oe_n && (!(&we_n) || dq_oe)) v_r7++;
    p_al = al; p_dl = dl; p_we = we_n; p_addr = s_addr; p_dq = dq_o; p_dq_oe = dq_oe;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic do_op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [NL-1:0] m, output int lat, output logic [DW-1:0] rd);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1; wr = w; addr = a; wdata = d; be = m;
    @(posedge clk);
    @(negedge clk);
    req = 0;
    lat = 0;
    check(!ready, "R2 busy after accept", ready, 0);
    while (!done && lat < 100) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    rd = rdata;
  endtask

  task automatic t_reset;
    check(ready === 1'b1 && done === 1'b0, "R1 handshake", {ready, done}, 2'b10);
    check(ce_n === 1'b1 && oe_n === 1'b1 && we_n === 2'b11, "R1 strobes",
          {ce_n, oe_n, we_n}, 4'hF);
    check(al === 1'b0 && dl === 1'b0 && dq_oe === 1'b0, "R1 latches", {al, dl, dq_oe}, 0);
  endtask

  task automatic t_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int lat; logic [DW-1:0] rd;
    do_op(1, a, d, 2'b11, lat, rd);
    check(lat == LAT_WR, "R8 write latency", lat, LAT_WR);
    @(negedge clk);
    check(ready, "R2 ready after done", ready, 1);
    do_op(0, a, '0, 2'b00, lat, rd);
    check(lat == LAT_RD, "R8 read latency", lat, LAT_RD);
    check(rd == d, "R7 R3 R4 read back", rd, d);
  endtask

  task automatic t_mask;
    int lat; logic [DW-1:0] rd;
    do_op(1, 16'h0042, 18'h3FFFF, 2'b11, lat, rd);
    do_op(1, 16'h0042, 18'h00000, 2'b01, lat, rd);
    do_op(0, 16'h0042, '0, 2'b00, lat, rd);
    check(rd == 18'h3FE00, "R5 lower lane only", rd, 18'h3FE00);
    do_op(1, 16'h0042, 18'h00000, 2'b10, lat, rd);
    do_op(0, 16'h0042, '0, 2'b00, lat, rd);
    check(rd == 18'h00000, "R5 upper lane only", rd, 0);
    do_op(1, 16'h0042, 18'h3FFFF, 2'b00, lat, rd);
    do_op(0, 16'h0042, '0, 2'b00, lat, rd);
    check(rd == 18'h00000, "R5 empty mask no effect", rd, 0);
    do_op(1, 16'h0042, 18'h3FFFF, 2'b10, lat, rd);
    do_op(0, 16'h0042, '0, 2'b00, lat, rd);
    check(rd == 18'h3FE00, "R5 upper lane set", rd, 18'h3FE00);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1; wr = 1; addr = 16'h0100; wdata = 18'h12345; be = 2'b11;
    @(negedge clk);
    while (!done) @(negedge clk);
    addr = 16'h0101; wdata = 18'h0BEEF;
    @(negedge clk);
    check(ready, "R9 idle cycle after done", ready, 1);
    @(negedge clk);
    check(!ready, "R9 held request accepted", ready, 0);
    req = 0;
    while (!done) @(negedge clk);
  endtask

  task automatic t_rdata_hold;
    int lat; logic [DW-1:0] rd;
    do_op(0, 16'h0100, '0, 2'b00, lat, rd);
    check(rd == 18'h12345, "R9 first back-to-back word", rd, 18'h12345);
    do_op(1, 16'h0200, 18'h00777, 2'b11, lat, rd);
    check(rd == 18'h12345, "R10 rdata held over write", rd, 18'h12345);
    do_op(0, 16'h0101, '0, 2'b00, lat, rd);
    check(rd == 18'h0BEEF, "R9 second back-to-back word", rd, 18'h0BEEF);
  endtask

  initial begin
    #3;
    t_reset;
    #20 rst_n = 1;
    @(negedge clk);
    t_reset;
    t_word(16'h1234, 18'h2ABCD);
    t_word(16'hFFFF, 18'h3FFFF);
    t_word(16'h0000, 18'h00001);
    t_mask;
    t_back_to_back;
    t_rdata_hold;
    repeat (3) @(negedge clk);
    check(v_r3 == 0, "R3 address latch window", v_r3, 0);
    check(v_r4 == 0, "R4 data latch window", v_r4, 0);
    check(v_r5 == 0, "R5 strobe width and enable", v_r5, 0);
    check(v_r6 == 0, "R6 address change with strobes high", v_r6, 0);
    check(v_r7 == 0, "R7 output enable overlap", v_r7, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule